// File: doc/BRIEF.md
# Interval-Mode Timer Counter

This block is one channel of a 32-bit timer. A prescaled tick enable, one cycle wide, advances the counter. The counter counts up or down. It either runs freely over the full 32-bit range or stays inside a programmable interval of N values (0 to N-1), wrapping back into that range at either end. Three compare values raise match events. A wrap raises either an interval event or an overflow event, depending on the mode. The events collect in a status register that clears when it is read. An enable mask reduces the status to one level interrupt.

Software reaches the block through a simple word-addressed bus. Writes take effect on the clock edge. Read data is combinational from the address and is valid in the same cycle. A read access of the status location clears it at the end of that cycle.

Top module: `ivl_timer`

## Requirements
- R1: After reset, every register and the counter read 0, and `irq` is low.
- R2: With control bit 0 (halt) clear, each cycle with `tick_en` high steps the counter by one; up is the default direction. With `tick_en` low or halt set, the counter holds its value.
- R3: Control bit 2 (down) set makes each tick decrement the counter by one.
- R4: Interval mode applies when control bit 1 is set and the interval register (address 2) holds N, with N not 0. An up-step from N-1 gives 0, and a down-step from 0 reloads N-1. Either wrap sets status bit 0 (interval flag) and never status bit 4.
- R5: Free mode applies when control bit 1 is clear, or when the interval is 0. The counter wraps at the 32-bit boundary (0xFFFFFFFF to 0 up, 0 to 0xFFFFFFFF down), and the wrap sets status bit 4 (overflow flag).
- R6: When a counting tick leaves the counter equal to match value i (addresses 3, 4 and 5 for i = 0, 1, 2), status bit i+1 is set. On a tick that wraps, the counter takes the wrapped value and the match is judged on that value, so both flags can be set together.
- R7: Writing control with bit 3 (restart) set loads the counter with 0 when the written down bit is 0. When the written down bit is 1, it loads the top of the range chosen by the written mode bit. The restart wins over a tick in the same cycle, and bit 3 always reads back as 0.
- R8: A read of status (address 6) returns its bits and clears them. An event in that same cycle stays set. Writes to status have no effect.
- R9: `irq` is high exactly when some status bit is set and its bit in the enable register (address 7, bits 4:0) is set.
- R10: If the interval is lowered below the counter, an up-tick wraps the counter to 0 and a down-tick loads N-1. Both count as wraps.
- R11: Control bits 2:0, the interval, the match values and the enable bits read back as written. The value location (address 1) ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled count enable |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address (0 ctrl, 1 value, 2 interval, 3..5 match, 6 status, 7 enable) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A wrap and a match can happen on the same tick. The bench provokes this by placing a match value at 0 in an up-counting interval. It also provokes it by lowering the interval under the counter while a match sits at the landing value. It then expects the counter on the wrapped value and both flags set in the status register. The status clear and a new event can also fall in the same cycle. The bench reads status on a tick that lands on a match. It expects the read to return the old bits and the next read to return only the new match flag. A behavioural model follows every cycle and checks the counter value and the interrupt line against it.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // control register bit positions
  localparam int CTL_HALT    = 0;
  localparam int CTL_IVL     = 1;
  localparam int CTL_DOWN    = 2;
  localparam int CTL_RESTART = 3;

  // word addresses; match i sits at A_MATCH0+i, status and enable follow
  localparam int A_CTRL     = 0;
  localparam int A_VALUE    = 1;
  localparam int A_INTERVAL = 2;
  localparam int A_MATCH0   = 3;

  typedef struct packed {
    logic down;
    logic ivl;
    logic halt;
  } ctrl_t;
endpackage

// File: rtl/ivt_regfile.sv
module ivt_regfile
  import ivt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 3,
  parameter int ADDR_W  = 3,
  parameter int ST_W    = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [CNT_W-1:0]                bus_wdata,
  input  logic [CNT_W-1:0]                cnt_i,
  input  logic [ST_W-1:0]                 status_i,
  output ctrl_t                           ctrl_o,
  output logic [CNT_W-1:0]                interval_o,
  output logic [N_MATCH-1:0][CNT_W-1:0]   match_o,
  output logic [ST_W-1:0]                 enable_o,
  output logic                            restart_o,
  output logic                            rst_down_o,
  output logic                            rst_ivl_o,
  output logic                            rd_clr_o,
  output logic [CNT_W-1:0]                rdata_o
);
  localparam int ST_ADDR = A_MATCH0 + N_MATCH;
  localparam int EN_ADDR = ST_ADDR + 1;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  logic wr_en, rd_en;
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] interval_q;
  logic [ST_W-1:0]  enable_q;
  logic [CNT_W-1:0] match_q [N_MATCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      interval_q <= '0;
      enable_q   <= '0;
    end else if (wr_en) begin
      if (at(bus_addr, A_CTRL)) begin
        ctrl_q.halt <= bus_wdata[CTL_HALT];
        ctrl_q.ivl  <= bus_wdata[CTL_IVL];
        ctrl_q.down <= bus_wdata[CTL_DOWN];
      end
      if (at(bus_addr, A_INTERVAL)) interval_q <= bus_wdata;
      if (at(bus_addr, EN_ADDR))    enable_q   <= bus_wdata[ST_W-1:0];
    end
  end

  for (genvar g = 0; g < N_MATCH; g++) begin : g_match
    always_ff @(posedge clk) begin
      if (!rst_n) match_q[g] <= '0;
      else if (wr_en && at(bus_addr, A_MATCH0 + g)) match_q[g] <= bus_wdata;
    end
    assign match_o[g] = match_q[g];
  end

  assign ctrl_o     = ctrl_q;
  assign interval_o = interval_q;
  assign enable_o   = enable_q;
  assign restart_o  = wr_en && at(bus_addr, A_CTRL) && bus_wdata[CTL_RESTART];
  assign rst_down_o = bus_wdata[CTL_DOWN];
  assign rst_ivl_o  = bus_wdata[CTL_IVL];
  assign rd_clr_o   = rd_en && at(bus_addr, ST_ADDR);

  always_comb begin
    rdata_o = '0;
    if (at(bus_addr, A_CTRL)) begin
      rdata_o[CTL_HALT] = ctrl_q.halt;
      rdata_o[CTL_IVL]  = ctrl_q.ivl;
      rdata_o[CTL_DOWN] = ctrl_q.down;
    end
    if (at(bus_addr, A_VALUE))    rdata_o = cnt_i;
    if (at(bus_addr, A_INTERVAL)) rdata_o = interval_q;
    for (int i = 0; i < N_MATCH; i++)
      if (at(bus_addr, A_MATCH0 + i)) rdata_o = match_q[i];
    if (at(bus_addr, ST_ADDR)) rdata_o[ST_W-1:0] = status_i;
    if (at(bus_addr, EN_ADDR)) rdata_o[ST_W-1:0] = enable_q;
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick_en,
  input  ctrl_t                         ctrl_i,
  input  logic [CNT_W-1:0]              interval_i,
  input  logic [N_MATCH-1:0][CNT_W-1:0] match_i,
  input  logic                          restart_i,
  input  logic                          rst_down_i,
  input  logic                          rst_ivl_i,
  output logic [CNT_W-1:0]              cnt_o,
  output logic                          step_o,
  output logic                          wrap_o,
  output logic                          use_ivl_o,
  output logic [N_MATCH-1:0]            hit_o
);
  // highest legal value for the chosen mode
  function automatic logic [CNT_W-1:0] top_of(input logic ivl,
                                              input logic [CNT_W-1:0] n);
    return (ivl && n != '0) ? n - CNT_W'(1) : '1;
  endfunction

  // one step: {wrapped, next value}
  function automatic logic [CNT_W:0] step_of(input logic down,
                                             input logic [CNT_W-1:0] c,
                                             input logic [CNT_W-1:0] top);
    if (down) begin
      if (c == '0 || c > top) return {1'b1, top};
      return {1'b0, c - CNT_W'(1)};
    end
    if (c >= top) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, c + CNT_W'(1)};
  endfunction

  logic [CNT_W-1:0] cnt_q, nxt, top_run, top_rst;
  logic             wrap_raw;

  assign top_run          = top_of(ctrl_i.ivl, interval_i);
  assign top_rst          = top_of(rst_ivl_i, interval_i);
  assign {wrap_raw, nxt}  = step_of(ctrl_i.down, cnt_q, top_run);
  assign step_o           = tick_en && !ctrl_i.halt && !restart_i;
  assign wrap_o           = step_o && wrap_raw;
  assign use_ivl_o        = ctrl_i.ivl && interval_i != '0;
  assign cnt_o            = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= rst_down_i ? top_rst : '0;
    else if (step_o)    cnt_q <= nxt;
  end

  for (genvar g = 0; g < N_MATCH; g++) begin : g_hit
    assign hit_o[g] = step_o && (nxt == match_i[g]);
  end
endmodule

// File: rtl/ivt_status.sv
module ivt_status #(
  parameter int N_MATCH = 3,
  parameter int ST_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrap_i,
  input  logic               use_ivl_i,
  input  logic [N_MATCH-1:0] hit_i,
  input  logic               rd_clr_i,
  input  logic [ST_W-1:0]    enable_i,
  output logic [ST_W-1:0]    status_o,
  output logic [ST_W-1:0]    set_o,
  output logic               irq_o
);
  localparam int OVF_BIT = N_MATCH + 1;

  logic [ST_W-1:0] status_q;

  always_comb begin
    set_o          = '0;
    set_o[0]       = wrap_i && use_ivl_i;
    set_o[OVF_BIT] = wrap_i && !use_ivl_i;
    for (int i = 0; i < N_MATCH; i++) set_o[i+1] = hit_i[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (rd_clr_i ? '0 : status_q) | set_o;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & enable_i);
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 3,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int ST_W = N_MATCH + 2;

  ctrl_t                         ctrl_w;
  logic [CNT_W-1:0]              interval_w, cnt_w;
  logic [N_MATCH-1:0][CNT_W-1:0] match_w;
  logic [ST_W-1:0]               enable_w, status_w, set_w;
  logic                          restart_w, rst_down_w, rst_ivl_w, rd_clr_w;
  logic                          step_w, wrap_w, use_ivl_w, down_w;
  logic [N_MATCH-1:0]            hit_w;

  assign down_w = ctrl_w.down;

  ivt_regfile #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .ADDR_W(ADDR_W), .ST_W(ST_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_i(cnt_w), .status_i(status_w),
    .ctrl_o(ctrl_w), .interval_o(interval_w), .match_o(match_w), .enable_o(enable_w),
    .restart_o(restart_w), .rst_down_o(rst_down_w), .rst_ivl_o(rst_ivl_w),
    .rd_clr_o(rd_clr_w), .rdata_o(bus_rdata)
  );

  ivt_counter #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_i(ctrl_w),
    .interval_i(interval_w), .match_i(match_w), .restart_i(restart_w),
    .rst_down_i(rst_down_w), .rst_ivl_i(rst_ivl_w), .cnt_o(cnt_w),
    .step_o(step_w), .wrap_o(wrap_w), .use_ivl_o(use_ivl_w), .hit_o(hit_w)
  );

  ivt_status #(.N_MATCH(N_MATCH), .ST_W(ST_W)) u_st (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap_w), .use_ivl_i(use_ivl_w),
    .hit_i(hit_w), .rd_clr_i(rd_clr_w), .enable_i(enable_w),
    .status_o(status_w), .set_o(set_w), .irq_o(irq)
  );
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 3,
  parameter int ST_W    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step,
  input logic               restart,
  input logic               rst_down,
  input logic               down,
  input logic               wrap,
  input logic               use_ivl,
  input logic [N_MATCH-1:0] hit,
  input logic [CNT_W-1:0]   cnt,
  input logic [ST_W-1:0]    status,
  input logic [ST_W-1:0]    set_vec,
  input logic [ST_W-1:0]    enable,
  input logic               rd_clr,
  input logic               irq
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> cnt == $past(cnt));

  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !down && !wrap) |=> cnt == $past(cnt) + CNT_W'(1));

  a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && down && !wrap) |=> cnt == $past(cnt) - CNT_W'(1));

  a_r4_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !down) |=> cnt == '0);

  a_r4_ivl_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && use_ivl) |=> status[0]);

  a_r5_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !use_ivl) |=> status[ST_W-1]);

  for (genvar g = 0; g < N_MATCH; g++) begin : g_m
    a_r6_match: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> status[g+1]);
  end

  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !rst_down) |=> cnt == '0);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_vec == '0) |=> status == '0);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(enable) == 0) |-> !irq);
endmodule

bind ivl_timer ivt_checker #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .ST_W(ST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step_w), .restart(restart_w),
  .rst_down(rst_down_w), .down(down_w), .wrap(wrap_w), .use_ivl(use_ivl_w),
  .hit(hit_w), .cnt(cnt_w), .status(status_w), .set_vec(set_w),
  .enable(enable_w), .rd_clr(rd_clr_w), .irq(irq)
);

// File: tb/sim_ivl_timer.sv
module sim_ivl_timer;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = 3'd1;
  logic [31:0] wd = '0;
  wire  [31:0] rdata;
  wire         irq;

  always #5 clk = ~clk;

  ivl_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_sel(sel), .bus_wr(wr),
                .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdata), .irq(irq));

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural reference
  bit     m_halt, m_ivl, m_down;
  longint m_int, m_cnt;
  longint m_match [3];
  int     m_en, m_st;

  always @(posedge clk) begin
    bit     rs, uivl, stp, wrp;
    longint modl, nx, rm;
    int     setb;
    if (!rst_n) begin
      m_halt = 0; m_ivl = 0; m_down = 0; m_int = 0; m_cnt = 0; m_en = 0; m_st = 0;
      foreach (m_match[i]) m_match[i] = 0;
    end else begin
      uivl = m_ivl && (m_int != 0);
      modl = uivl ? m_int : 64'h1_0000_0000;
      rs   = sel && wr && addr == 0 && wd[3];
      stp  = tick && !m_halt && !rs;
      setb = 0;
      if (stp) begin
        if (m_down) begin
          wrp = (m_cnt == 0) || (m_cnt >= modl);
          nx  = wrp ? modl - 1 : m_cnt - 1;
        end else begin
          wrp = (m_cnt + 1 >= modl);
          nx  = wrp ? 0 : m_cnt + 1;
        end
        if (wrp) setb |= uivl ? 1 : 16;
        for (int i = 0; i < 3; i++) if (nx == m_match[i]) setb |= (1 << (i + 1));
        m_cnt = nx;
      end
      if (rs) begin
        rm    = (wd[1] && m_int != 0) ? m_int : 64'h1_0000_0000;
        m_cnt = wd[2] ? rm - 1 : 0;
      end
      if (sel && !wr && addr == 6) m_st = 0;
      m_st |= setb;
      if (sel && wr) begin
        case (addr)
          3'd0: begin m_halt = wd[0]; m_ivl = wd[1]; m_down = wd[2]; end
          3'd2: m_int = wd;
          3'd3: m_match[0] = wd;
          3'd4: m_match[1] = wd;
          3'd5: m_match[2] = wd;
          3'd7: m_en = int'(wd[4:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string t, longint act, longint exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  // per-cycle comparison, then drive this cycle's access
  task automatic cyc(bit s, bit w, logic [2:0] a, logic [31:0] d, bit tk);
    @(negedge clk); #1;
    sel = 0; addr = 3'd1; #1;
    check(tag, rdata, m_cnt, "counter value");
    check(tag, irq, ((m_st & m_en) != 0), "irq");
    sel = s; wr = w; addr = a; wd = d; tick = tk;
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d, bit tk = 0);
    cyc(1, 1, a, d, tk);
  endtask

  task automatic rdc(logic [2:0] a, longint exp, string what, bit tk = 0);
    cyc(1, 0, a, '0, tk); #2;
    check(tag, rdata, exp, what);
  endtask

  task automatic idle(int n, bit tk);
    repeat (n) cyc(0, 0, 3'd1, '0, tk);
  endtask

  task automatic chk_irq(bit exp, string what);
    idle(1, 0); #2;
    check(tag, irq, exp, what);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    tag = "R1";
    rdc(0, 0, "ctrl after reset");
    rdc(1, 0, "value after reset");
    rdc(2, 0, "interval after reset");
    rdc(6, 0, "status after reset");
    rdc(7, 0, "enable after reset");
    // R11 readback of plain registers
    tag = "R11";
    wreg(3, 32'h1000); wreg(4, 32'h2000); wreg(5, 32'h3000);
    rdc(3, 32'h1000, "match0 readback");
    rdc(5, 32'h3000, "match2 readback");
    wreg(7, 32'hFFFF_FFFF);
    rdc(7, 32'h1F, "enable keeps 5 bits");
    wreg(7, 0);
    // R2 up counting, hold
    tag = "R2";
    idle(5, 1);
    rdc(1, 5, "five ticks");
    idle(3, 0);
    rdc(1, 5, "no tick holds");
    wreg(0, 32'h1);
    idle(3, 1);
    rdc(1, 5, "halt holds");
    // R7 restart beats tick
    tag = "R7";
    wreg(0, 32'h8, 1);
    rdc(1, 0, "restart up loads 0");
    rdc(0, 0, "restart bit reads 0");
    // R3 down counting
    tag = "R3";
    wreg(0, 32'hC);
    rdc(1, 32'hFFFF_FFFF, "restart down free loads all ones");
    idle(3, 1);
    rdc(1, 32'hFFFF_FFFC, "three down ticks");
    // R5 free-mode wraps
    tag = "R5";
    wreg(0, 32'h0);
    idle(4, 1);
    rdc(1, 0, "up wrap to 0");
    rdc(6, 32'h10, "overflow flag up");
    rdc(6, 0, "cleared");
    wreg(0, 32'h8); wreg(0, 32'h4);
    idle(1, 1);
    rdc(1, 32'hFFFF_FFFF, "down underflow");
    rdc(6, 32'h10, "overflow flag down");
    // R4 interval mode
    tag = "R4";
    wreg(2, 5);
    wreg(0, 32'hA);
    idle(7, 1);
    rdc(1, 2, "up modulo 5");
    rdc(6, 1, "interval flag up");
    wreg(0, 32'hE);
    rdc(1, 4, "restart down loads N-1");
    idle(5, 1);
    rdc(1, 4, "down reload N-1");
    rdc(6, 1, "interval flag on down wrap, no overflow");
    // R6 match and wrap+match
    tag = "R6";
    wreg(3, 2); wreg(4, 3); wreg(5, 0);
    wreg(0, 32'hA);
    idle(2, 1);
    rdc(6, 2, "match0");
    idle(1, 1);
    rdc(6, 4, "match1");
    idle(2, 1);
    rdc(1, 0, "wrapped value");
    rdc(6, 9, "wrap and match2 together");
    // R8 clear with concurrent event, status write ignored
    tag = "R8";
    idle(1, 1);
    rdc(6, 0, "read during event", 1);
    rdc(6, 2, "event survives clear");
    wreg(6, 32'h1F);
    rdc(6, 0, "status write ignored");
    // R9 interrupt masking
    tag = "R9";
    wreg(7, 2);
    idle(5, 1);
    chk_irq(1, "enabled match0 raises irq");
    wreg(7, 0);
    chk_irq(0, "masked");
    wreg(7, 32'h10);
    chk_irq(0, "only overflow enabled");
    wreg(7, 1);
    chk_irq(1, "interval flag enabled");
    rdc(6, 32'hF, "all four event flags");
    chk_irq(0, "cleared status drops irq");
    wreg(7, 0);
    // R10 interval lowered under counter
    tag = "R10";
    wreg(2, 10);
    wreg(0, 32'hA);
    idle(8, 1);
    rdc(6, 6, "matches at 2 and 3");
    wreg(2, 4);
    idle(1, 1);
    rdc(1, 0, "up out of range to 0");
    rdc(6, 9, "wrap plus match at 0");
    wreg(2, 10);
    wreg(0, 32'hE);
    idle(1, 1);
    wreg(2, 4);
    idle(1, 1);
    rdc(1, 3, "down out of range to N-1");
    rdc(6, 5, "wrap plus match at 3");
    // R11 value write ignored, ctrl readback
    tag = "R11";
    wreg(1, 32'h1234);
    rdc(1, 3, "value ignores writes");
    wreg(0, 32'hF);
    rdc(0, 7, "ctrl readback without restart bit");
    rdc(2, 4, "interval readback");
    idle(2, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule